// File: doc/BRIEF.md
# Variable-Width CRC-32 / CRC-32C Accumulator Step

This unit advances a 32-bit cyclic redundancy check accumulator by one, two, four or eight bytes taken from a 64-bit data word. The caller supplies the running accumulator, the data word, a size code and a polynomial choice. One cycle after the request is accepted, the unit presents the updated accumulator. Two bit-reflected polynomials are available: the common CRC-32 and the Castagnoli CRC-32C.

The accumulator is used raw. The unit neither inverts the value on entry nor complements it on exit, so the caller applies any seeding or final complement. A message longer than eight bytes is processed by a sequence of requests: each request takes the previous result as its accumulator input. The output side holds its result under a valid/ready handshake until the consumer takes it. A new request can be accepted in the same cycle that the held result is taken.

Top module: `crc_acc_unit`

## Requirements
- R1: While reset (`rstN` low) is applied and in the first cycle after it, `outValid` is 0 and `inReady` is 1.
- R2: A request is accepted on a rising clock edge at which `inValid` and `inReady` are both 1. `outValid` is then 1 after that same edge, and `crcOut` holds the result of the request.
- R3: With `polySel` = 0, the update uses the reflected polynomial 0xEDB88320. Each byte is XORed into bits 7:0 of the accumulator, and then eight right-shift steps follow. A step XORs in the polynomial when the bit shifted out is 1. No inversion is applied on entry or on exit.
- R4: With `polySel` = 1, the update is the same except that the reflected polynomial is 0x82F63B78.
- R5: `sizeCode` selects how many bytes are consumed: 0 consumes 1 byte, 1 consumes 2, 2 consumes 4 and 3 consumes 8. Bytes are taken from the least significant end of `dataIn`: byte k is `dataIn[8k+7:8k]`, and byte 0 is processed first.
- R6: Bytes of `dataIn` above the selected count have no effect on `crcOut`.
- R7: While `outValid` is 1 and `outReady` is 0, `inReady` is 0, `outValid` stays 1 and `crcOut` does not change.
- R8: When `outValid` and `outReady` are both 1 and no request is accepted at that edge, `outValid` is 0 after the edge.
- R9: When `outValid` and `outReady` are both 1, `inReady` is 1. A request accepted at that edge replaces the result, so the unit sustains one request per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Unit can accept a request |
| accIn | input | 32 | Accumulator value before the update |
| dataIn | input | 64 | Data bytes, little-endian |
| sizeCode | input | 2 | Byte count code: 0=1, 1=2, 2=4, 3=8 |
| polySel | input | 1 | 0 = CRC-32, 1 = CRC-32C |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| crcOut | output | 32 | Updated accumulator |

## Verification
The only internal state is the held result and its valid flag. A wrong flag shows at the ports on the very next cycle: it appears as a lost result, a duplicated result or a wrong `inReady`. A wrong result register shows in the `crcOut` value presented in the cycle after acceptance. A fault in the byte-step chain or the size selection appears only for the polynomial or size code that reaches the faulty logic. For that reason the bench covers every size code with both polynomials, uses data with non-zero bytes above the selected count, and checks chained known-answer messages against published check values.

// File: rtl/crc_acc_pkg.sv
package crc_acc_pkg;
  localparam int unsigned CRC_W = 32;
  localparam int unsigned DATA_BYTES = 8;
  localparam int unsigned SIZE_COUNT = $clog2(DATA_BYTES) + 1;
  localparam int unsigned SIZE_W = $clog2(SIZE_COUNT);

  typedef enum logic {
    POLY_IEEE = 1'b0,
    POLY_CASTAGNOLI = 1'b1
  } polyKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } ctrlStrobes_t;
endpackage

// File: rtl/crc_acc_byte_step.sv
module crc_acc_byte_step #(
  parameter int unsigned CRC_W = 32
) (
  input  logic [CRC_W-1:0] crcIn,
  input  logic [7:0]       dataByte,
  input  logic [CRC_W-1:0] poly,
  output logic [CRC_W-1:0] crcNext
);
  logic [CRC_W-1:0] work;

  always_comb begin
    work = crcIn ^ {{(CRC_W-8){1'b0}}, dataByte};
    for (int b = 0; b < 8; b++) begin
      if (work[0]) work = (work >> 1) ^ poly;
      else         work = work >> 1;
    end
  end

  assign crcNext = work;
endmodule

// File: rtl/crc_acc_datapath.sv
module crc_acc_datapath
  import crc_acc_pkg::*;
#(
  parameter int unsigned CRC_W = 32,
  parameter int unsigned DATA_BYTES = 8,
  parameter logic [CRC_W-1:0] POLY_A = 32'hEDB88320,
  parameter logic [CRC_W-1:0] POLY_B = 32'h82F63B78,
  localparam int unsigned SIZE_COUNT = $clog2(DATA_BYTES) + 1,
  localparam int unsigned SIZE_W = $clog2(SIZE_COUNT)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [CRC_W-1:0]      accIn,
  input  logic [8*DATA_BYTES-1:0] dataIn,
  input  logic [SIZE_W-1:0]     sizeCode,
  input  polyKind_t             polySel,
  output logic [CRC_W-1:0]      crcOut
);
  logic [CRC_W-1:0] activePoly;
  logic [CRC_W-1:0] chain [DATA_BYTES+1];
  logic [CRC_W-1:0] selected;
  logic [CRC_W-1:0] resultQ;

  assign activePoly = (polySel == POLY_CASTAGNOLI) ? POLY_B : POLY_A;
  assign chain[0] = accIn;

  for (genvar g = 0; g < DATA_BYTES; g++) begin : gStep
    crc_acc_byte_step #(.CRC_W(CRC_W)) step_i (
      .crcIn   (chain[g]),
      .dataByte(dataIn[8*g +: 8]),
      .poly    (activePoly),
      .crcNext (chain[g+1])
    );
  end

  // tap the chain after 2**sizeCode bytes
  always_comb begin
    selected = chain[1];
    for (int k = 0; k < SIZE_COUNT; k++) begin
      if (sizeCode == SIZE_W'(k)) selected = chain[1 << k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             resultQ <= '0;
    else if (strobes.load) resultQ <= selected;
  end

  assign crcOut = resultQ;
endmodule

// File: rtl/crc_acc_control.sv
module crc_acc_control
  import crc_acc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  logic holdQ;

  assign inReady = !holdQ || outReady;
  assign strobes.load = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN)             holdQ <= 1'b0;
    else if (strobes.load) holdQ <= 1'b1;
    else if (outReady)     holdQ <= 1'b0;
  end

  assign outValid = holdQ;
endmodule

// File: rtl/crc_acc_unit.sv
module crc_acc_unit
  import crc_acc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [CRC_W-1:0]        accIn,
  input  logic [8*DATA_BYTES-1:0] dataIn,
  input  logic [SIZE_W-1:0]       sizeCode,
  input  logic                    polySel,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [CRC_W-1:0]        crcOut
);
  ctrlStrobes_t strobes;

  crc_acc_control ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobes (strobes)
  );

  crc_acc_datapath #(.CRC_W(CRC_W), .DATA_BYTES(DATA_BYTES)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .accIn   (accIn),
    .dataIn  (dataIn),
    .sizeCode(sizeCode),
    .polySel (polyKind_t'(polySel)),
    .crcOut  (crcOut)
  );
endmodule

// File: rtl/crc_acc_checker.sv
module crc_acc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic [31:0] accIn,
  input logic [63:0] dataIn,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] crcOut
);
  a_r2_accept_gives_valid: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(crcOut)));

  a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  a_r8_drain_clears: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inValid) |=> !outValid);

  a_r9_take_allows_accept: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |-> inReady);

  // R3/R4: zero accumulator and zero data stay zero for any polynomial and size
  a_r3_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && accIn == 32'h0 && dataIn == 64'h0) |=> (crcOut == 32'h0));
endmodule

bind crc_acc_unit crc_acc_checker chk_i (.*);

// File: tb/crc_acc_unit_tb_top.sv
module crc_acc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] accIn = '0;
  logic [63:0] dataIn = '0;
  logic [1:0]  sizeCode = '0;
  logic        polySel = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] crcOut;

  int checks = 0;
  int failures = 0;
  string curReq = "R2";
  bit modelOn = 1'b0;

  always #5 clk = ~clk;

  crc_acc_unit dut_i (.*);

  function automatic logic [31:0] refCrc(input logic [31:0] acc, input logic [63:0] d,
                                         input int nB, input bit castagnoli);
    logic [31:0] p = castagnoli ? 32'h82F63B78 : 32'hEDB88320;
    for (int i = 0; i < nB; i++) begin
      acc ^= {24'h0, d[8*i +: 8]};
      for (int b = 0; b < 8; b++) acc = acc[0] ? ((acc >> 1) ^ p) : (acc >> 1);
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit          expValid = 1'b0;
  logic [31:0] expCrc = '0;
  always @(posedge clk) begin
    if (!rstN) expValid <= 1'b0;
    else if (inValid && (!expValid || outReady)) begin
      expValid <= 1'b1;
      expCrc <= refCrc(accIn, dataIn, 1 << sizeCode, polySel);
    end else if (outReady) expValid <= 1'b0;
  end

  always @(negedge clk) begin
    if (rstN && modelOn) begin
      check({curReq, " outValid"}, {31'h0, outValid}, {31'h0, expValid});
      check({curReq, " inReady"}, {31'h0, inReady}, {31'h0, (!expValid || outReady)});
      if (expValid) check({curReq, " crcOut"}, crcOut, expCrc);
    end
  end

  task automatic sendReq(input logic [31:0] a, input logic [63:0] d, input logic [1:0] s, input bit p);
    @(posedge clk); #2;
    inValid = 1'b1; accIn = a; dataIn = d; sizeCode = s; polySel = p;
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    @(posedge clk); #2;
    inValid = 1'b0;
  endtask

  task automatic knownAnswer(input bit p, input logic [31:0] golden, input string req);
    logic [31:0] mid;
    outReady = 1'b1;
    sendReq(32'hFFFFFFFF, 64'h3837363534333231, 2'd3, p);
    @(negedge clk); mid = crcOut;
    sendReq(mid, 64'h39, 2'd0, p);
    @(negedge clk);
    check(req, crcOut ^ 32'hFFFFFFFF, golden);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outValid", {31'h0, outValid}, 32'h0);
    check("R1 reset inReady", {31'h0, inReady}, 32'h1);
    @(posedge clk); #2 rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset outValid", {31'h0, outValid}, 32'h0);
    modelOn = 1'b1;

    curReq = "R3"; knownAnswer(1'b0, 32'hCBF43926, "R3 crc32 check value");
    curReq = "R4"; knownAnswer(1'b1, 32'hE3069283, "R4 crc32c check value");

    curReq = "R5";
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 2; p++)
        sendReq($urandom, {$urandom, $urandom} & ((s == 3) ? 64'hFFFFFFFFFFFFFFFF : ((64'h1 << (8 << s)) - 1)),
                2'(s), p[0]);

    curReq = "R6";
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < 2; p++)
        sendReq($urandom, {$urandom, $urandom} | 64'hA5A5_0000_0000_0000, 2'(s), p[0]);

    curReq = "R7";
    @(posedge clk); #2 outReady = 1'b0;
    sendReq(32'h1234_5678, 64'hDEAD_BEEF_0102_0304, 2'd3, 1'b1);
    @(posedge clk); #2 inValid = 1'b1; accIn = 32'h0BAD_F00D; dataIn = 64'h77;
    repeat (4) @(posedge clk);
    #2 outReady = 1'b1;
    @(posedge clk); #2 inValid = 1'b0;

    curReq = "R8";
    repeat (3) @(posedge clk);

    curReq = "R9";
    #2 inValid = 1'b1;
    for (int i = 0; i < 12; i++) begin
      accIn = $urandom; dataIn = {$urandom, $urandom}; sizeCode = 2'(i % 4); polySel = i[0];
      @(posedge clk); #2;
    end
    inValid = 1'b0;

    curReq = "R2";
    for (int i = 0; i < 300; i++) begin
      inValid = $urandom_range(0, 1) == 1; outReady = $urandom_range(0, 2) != 0;
      accIn = $urandom; dataIn = {$urandom, $urandom};
      sizeCode = 2'($urandom_range(0, 3)); polySel = $urandom_range(0, 1) == 1;
      @(posedge clk); #2;
    end
    inValid = 1'b0; outReady = 1'b1;
    repeat (3) @(posedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule